// File: doc/BRIEF.md
# Condition-Code Branch Resolution Unit

This block keeps the two pieces of processor status that a conditional branch needs: a 2-bit condition code and the current instruction address. Compare and test operations write the condition code. A branch request supplies a 4-bit mask and a target address. The unit uses the stored condition code to select one mask bit. If that bit is 1, the instruction address is replaced with the target. If it is 0, the address moves on by one branch-instruction length.

Requests arrive one per cycle from an execution pipeline that has already decoded the instruction and formed the effective target. The unit answers on the cycle after each branch request. It presents the resulting instruction address and a one-cycle taken flag, and the fetch stage uses these to choose the next fetch.

Top module: `ccbr_unit`

## Requirements
- R1: A synchronous active-low reset sets the condition code to 00, loads the instruction address with `RESET_VEC` with bit 0 cleared, and clears `br_taken`.
- R2: A compare request writes the condition code from an unsigned comparison of `cmp_a` with `cmp_b`: 00 when they are equal, 01 when `cmp_a` is smaller, and 10 when `cmp_a` is larger.
- R3: A test request writes the condition code from `tst_val` read as a two's-complement number: 00 for zero, 01 for negative, and 10 for positive.
- R4: The branch is taken exactly when the mask bit selected by the condition code is 1. Mask bit 3 selects code 00, bit 2 selects code 01, bit 1 selects code 10, and bit 0 selects code 11.
- R5: In the cycle after a taken branch, `next_addr` equals `br_target` with bit 0 cleared, and `br_taken` is 1.
- R6: In the cycle after a branch that is not taken, `next_addr` equals the previous address plus 4, wrapping modulo 2^24, and `br_taken` is 0.
- R7: Mask 0000 never branches, whatever the condition code. Mask 1111 always branches.
- R8: A condition code written by a compare or test is the one used by a branch issued in the next cycle.
- R9: A branch request never changes the condition code.
- R10: When requests coincide, a branch request wins and any compare or test in the same cycle is dropped. When a compare and a test coincide without a branch, the compare wins.
- R11: In a cycle with no branch request, `next_addr` holds its value and `br_taken` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_req | input | 1 | Compare request |
| cmp_a | input | 32 | First compare operand, unsigned |
| cmp_b | input | 32 | Second compare operand, unsigned |
| tst_req | input | 1 | Test request |
| tst_val | input | 32 | Signed value to test |
| br_req | input | 1 | Branch-on-condition request |
| br_mask | input | 4 | Condition-selection mask |
| br_target | input | 24 | Branch target address |
| next_addr | output | 24 | Current instruction address, which is the next fetch address |
| br_taken | output | 1 | High for one cycle after a taken branch |

## Verification
The condition code has no output of its own. A wrong condition code only becomes visible when a later branch chooses the wrong mask bit. The error then shows up one cycle after that branch, as a wrong `br_taken` and a wrong `next_addr`: either the target when a fall-through was due, or address plus 4 when the target was due. For this reason every stimulus that sets the condition code is followed at once by a branch whose mask tells the codes apart. A corrupted address register shows at `next_addr` in the very next cycle, including idle cycles when it must stay unchanged.

// File: rtl/ccbr_pkg.sv
// Package: shared types and sizes for the condition-code branch unit.
// Assumes: the condition code is 2 bits and the mask carries one bit per code.
package ccbr_pkg;
    localparam int CC_W   = 2;
    localparam int N_CC   = 1 << CC_W;
    localparam int MASK_W = N_CC;

    typedef enum logic [CC_W-1:0] {
        CC_ZERO = 2'b00,
        CC_LOW  = 2'b01,
        CC_HIGH = 2'b10,
        CC_OVF  = 2'b11
    } cc_e;
endpackage

// File: rtl/ccbr_cc_gen.sv
// Module: ccbr_cc_gen
// Works out the condition code that a compare or test produces, and whether
// the stored code is written this cycle. A branch request suppresses both
// writes. A compare wins over a test.
// Assumes: compare operands are unsigned and the test operand is two's complement.
module ccbr_cc_gen
    import ccbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              cmp_req,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              tst_req,
    input  logic [DATA_W-1:0] tst_val,
    input  logic              br_req,
    output logic              cc_we,
    output cc_e               cc_new
);
    localparam int SIGN_BIT = DATA_W - 1;

    cc_e cmp_cc;
    cc_e tst_cc;

    // Purpose: classify the unsigned comparison of the two operands.
    always_comb begin
        if (cmp_a == cmp_b)     cmp_cc = CC_ZERO;
        else if (cmp_a < cmp_b) cmp_cc = CC_LOW;
        else                    cmp_cc = CC_HIGH;
    end

    // Purpose: classify the signed test operand as zero, negative or positive.
    always_comb begin
        if (tst_val == '0)        tst_cc = CC_ZERO;
        else if (tst_val[SIGN_BIT]) tst_cc = CC_LOW;
        else                      tst_cc = CC_HIGH;
    end

    // Purpose: apply the request priority (branch, then compare, then test).
    always_comb begin
        cc_we  = !br_req && (cmp_req || tst_req);
        cc_new = cmp_req ? cmp_cc : tst_cc;
    end
endmodule

// File: rtl/ccbr_branch_eval.sv
// Module: ccbr_branch_eval
// Decides whether a branch is taken. Each condition code has a slot; the slot
// for code g reads mask bit (MASK_W-1-g), so the mask's top bit belongs to code 00.
// Assumes: exactly one slot matches the current code.
module ccbr_branch_eval
    import ccbr_pkg::*;
(
    input  cc_e               cc,
    input  logic [MASK_W-1:0] mask,
    output logic              taken
);
    logic [N_CC-1:0] hit;

    for (genvar g = 0; g < N_CC; g++) begin : g_slot
        // Purpose: the slot fires when the code matches g and its mask bit is set.
        always_comb hit[g] = mask[MASK_W-1-g] && (cc == cc_e'(g));
    end

    // Purpose: merge the per-code slots into the branch decision.
    always_comb taken = |hit;
endmodule

// File: rtl/ccbr_addr_seq.sv
// Module: ccbr_addr_seq
// Holds the instruction address and the registered taken flag. A taken branch
// loads the target with bit 0 cleared. A branch that is not taken advances the
// address by INSTR_LEN. Without a branch the address holds.
// Assumes: reset is synchronous and active low.
module ccbr_addr_seq #(
    parameter int              ADDR_W    = 24,
    parameter int              INSTR_LEN = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = 24'h001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_req,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] addr_q,
    output logic              taken_q
);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(INSTR_LEN);
    localparam logic [ADDR_W-1:0] EVEN_MSK = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] RST_ADDR = RESET_VEC & EVEN_MSK;

    logic [ADDR_W-1:0] tgt_even;

    // Purpose: align the target to an even address.
    always_comb tgt_even = target & EVEN_MSK;

    // Purpose: update the instruction address and the taken flag each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= RST_ADDR;
            taken_q <= 1'b0;
        end else begin
            taken_q <= br_req && taken;
            if (br_req) addr_q <= taken ? tgt_even : addr_q + STEP;
        end
    end

    // Assertions (R5, R6, R11): address sequencing
    a_r5_taken_loads_target: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && taken) |=> (taken_q && addr_q == $past(tgt_even)));
    a_r6_fallthrough_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !taken) |=> (!taken_q && addr_q == $past(addr_q) + STEP));
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !br_req |=> (!taken_q && $stable(addr_q)));
    a_r5_addr_even: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[0] == 1'b0);
endmodule

// File: rtl/ccbr_unit.sv
// Module: ccbr_unit (top)
// Condition-code branch resolution unit. Holds the condition code, which is
// written by compares and tests, and resolves branch-on-condition requests
// against it to give the next instruction address.
// Assumes: the upstream pipeline issues at most one request per cycle. If
// requests coincide, the priority is branch, then compare, then test.
module ccbr_unit
    import ccbr_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 24,
    parameter int                INSTR_LEN = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = 24'h001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_req,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              tst_req,
    input  logic [DATA_W-1:0] tst_val,
    input  logic              br_req,
    input  logic [MASK_W-1:0] br_mask,
    input  logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] next_addr,
    output logic              br_taken
);
    cc_e  cc_q;
    cc_e  cc_new;
    logic cc_we;
    logic taken_now;

    ccbr_cc_gen #(.DATA_W(DATA_W)) u_cc_gen (
        .cmp_req (cmp_req),
        .cmp_a   (cmp_a),
        .cmp_b   (cmp_b),
        .tst_req (tst_req),
        .tst_val (tst_val),
        .br_req  (br_req),
        .cc_we   (cc_we),
        .cc_new  (cc_new)
    );

    // Purpose: hold the condition code and write it on compare or test.
    always_ff @(posedge clk) begin
        if (!rst_n)     cc_q <= CC_ZERO;
        else if (cc_we) cc_q <= cc_new;
    end

    ccbr_branch_eval u_eval (
        .cc    (cc_q),
        .mask  (br_mask),
        .taken (taken_now)
    );

    ccbr_addr_seq #(
        .ADDR_W    (ADDR_W),
        .INSTR_LEN (INSTR_LEN),
        .RESET_VEC (RESET_VEC)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .br_req  (br_req),
        .taken   (taken_now),
        .target  (br_target),
        .addr_q  (next_addr),
        .taken_q (br_taken)
    );

    // Assertions (R7, R9, R2, R10): decision and condition-code guards
    a_r7_mask_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_mask == '0) |=> !br_taken);
    a_r7_mask_full_always: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_mask == '1) |=> br_taken);
    a_r9_branch_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
        br_req |=> $stable(cc_q));
    a_r2_equal_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && !br_req && cmp_a == cmp_b) |=> (cc_q == CC_ZERO));
    a_r10_idle_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_req && !tst_req) |=> $stable(cc_q));
endmodule

// File: tb/ccbr_unit_tb.sv
`timescale 1ns/1ps
// Testbench for ccbr_unit. A vector table is walked first: each entry sets the
// condition code and then issues a branch. Directed tests for reset, priority,
// idle cycles and wrap follow.
module ccbr_unit_tb;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam logic [AW-1:0] RV = 24'h001000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_req = 1'b0, tst_req = 1'b0, br_req = 1'b0;
    logic [DW-1:0] cmp_a = '0, cmp_b = '0, tst_val = '0;
    logic [3:0]    br_mask = '0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] next_addr;
    logic          br_taken;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] exp_addr;

    always #2.5 clk = ~clk;

    ccbr_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmp_req(cmp_req), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .tst_req(tst_req), .tst_val(tst_val),
        .br_req(br_req), .br_mask(br_mask), .br_target(br_target),
        .next_addr(next_addr), .br_taken(br_taken)
    );

    // kind: 0 = compare a with b, 1 = test a
    typedef struct packed {
        logic          kind;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [3:0]    mask;
        logic          taken;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd5,        32'd5, 4'd8,  1'b1},  // R2 equal, R4
        '{1'b0, 32'd5,        32'd5, 4'd7,  1'b0},  // not-equal mask
        '{1'b0, 32'd3,        32'd9, 4'd4,  1'b1},  // R2 low
        '{1'b0, 32'd3,        32'd9, 4'd11, 1'b0},  // not-low mask
        '{1'b0, 32'd9,        32'd3, 4'd2,  1'b1},  // R2 high
        '{1'b0, 32'd9,        32'd3, 4'd13, 1'b0},  // not-high mask
        '{1'b0, 32'hFFFFFFFF, 32'd1, 4'd2,  1'b1},  // R2 unsigned high
        '{1'b1, 32'd0,        32'd0, 4'd8,  1'b1},  // R3 zero
        '{1'b1, 32'hFFFFFFFB, 32'd0, 4'd4,  1'b1},  // R3 minus
        '{1'b1, 32'hFFFFFFFB, 32'd0, 4'd2,  1'b0},  // minus, plus mask
        '{1'b1, 32'd7,        32'd0, 4'd2,  1'b1},  // R3 plus
        '{1'b1, 32'd7,        32'd0, 4'd13, 1'b0},  // not-plus mask
        '{1'b0, 32'd1,        32'd2, 4'd0,  1'b0},  // R7 mask 0
        '{1'b0, 32'd1,        32'd2, 4'd15, 1'b1},  // R7 mask 15
        '{1'b1, 32'h80000000, 32'd0, 4'd1,  1'b0},  // most negative, overflow-only mask
        '{1'b1, 32'h7FFFFFFF, 32'd0, 4'd5,  1'b0}   // R4 plus with 0101
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of requests at the falling edge, let the rising edge
    // capture them, sample at the next falling edge, then clear the requests.
    task automatic cycle(input logic c, input logic t, input logic b);
        cmp_req = c; tst_req = t; br_req = b;
        @(posedge clk);
        @(negedge clk);
        cmp_req = 1'b0; tst_req = 1'b0; br_req = 1'b0;
    endtask

    task automatic branch(input logic [3:0] m, input logic [AW-1:0] tg,
                          input logic exp_t, input string req);
        br_mask = m; br_target = tg;
        cycle(1'b0, 1'b0, 1'b1);
        exp_addr = exp_t ? (tg & ~AW'(1)) : exp_addr + AW'(4);
        chk(req, 32'(br_taken), 32'(exp_t));
        chk(req, 32'(next_addr), 32'(exp_addr));
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [AW-1:0] held;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_addr = RV;
        chk("R1 reset addr", 32'(next_addr), 32'(RV));
        chk("R1 reset taken", 32'(br_taken), 32'd0);
        branch(4'd8, 24'h000400, 1'b1, "R1 reset cc zero");

        // Vector table: set the code, branch in the next cycle (R8).
        for (int i = 0; i < NV; i++) begin
            cmp_a = VECS[i].a; cmp_b = VECS[i].b; tst_val = VECS[i].a;
            cycle(!VECS[i].kind, VECS[i].kind, 1'b0);
            branch(VECS[i].mask, AW'(24'h100000 + i * 64 + (i % 2)),
                   VECS[i].taken, $sformatf("R8 R4 R5 R6 vec %0d", i));
        end

        // R9: a branch leaves the code alone, so a second branch sees the same code.
        cmp_a = 32'd1; cmp_b = 32'd2; cycle(1'b1, 1'b0, 1'b0);
        branch(4'd4, 24'h002000, 1'b1, "R9 first");
        branch(4'd4, 24'h002100, 1'b1, "R9 second");

        // R10: a compare issued with a branch is dropped.
        cmp_a = 32'd7; cmp_b = 32'd7; cycle(1'b1, 1'b0, 1'b0);
        cmp_a = 32'd1; cmp_b = 32'd2; br_mask = 4'd8; br_target = 24'h003000;
        cycle(1'b1, 1'b0, 1'b1);
        exp_addr = 24'h003000;
        chk("R10 branch wins", 32'(br_taken), 32'd1);
        branch(4'd8, 24'h003100, 1'b1, "R10 compare dropped");
        // R10: a test issued with a branch is dropped.
        tst_val = 32'd5; br_mask = 4'd8; br_target = 24'h003200;
        cycle(1'b0, 1'b1, 1'b1);
        exp_addr = 24'h003200;
        chk("R10 branch over test", 32'(br_taken), 32'd1);
        branch(4'd8, 24'h003300, 1'b1, "R10 test dropped");
        // R10: compare wins over test.
        cmp_a = 32'd4; cmp_b = 32'd4; tst_val = 32'hFFFFFFFF;
        cycle(1'b1, 1'b1, 1'b0);
        branch(4'd8, 24'h003400, 1'b1, "R10 compare over test");

        // R11: idle cycles hold the address and keep taken low.
        held = next_addr;
        cycle(1'b0, 1'b0, 1'b0);
        chk("R11 idle addr", 32'(next_addr), 32'(held));
        chk("R11 idle taken", 32'(br_taken), 32'd0);

        // R6: the fall-through wraps at the top of the address space.
        branch(4'd15, 24'hFFFFFD, 1'b1, "R5 odd target cleared");
        branch(4'd0, 24'h000800, 1'b0, "R6 wrap");
        chk("R6 wrap value", 32'(next_addr), 32'd0);

        // R1: a reset in mid-run restores the vector and the zero code.
        rst_n = 1'b0; cycle(1'b0, 1'b0, 1'b0); rst_n = 1'b1;
        exp_addr = RV;
        chk("R1 re-reset addr", 32'(next_addr), 32'(RV));
        branch(4'd7, 24'h005000, 1'b0, "R1 re-reset cc");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule